// File: doc/BRIEF.md
# Machine Check Bank Recorder

This block keeps a parameterised set of machine-check banks. Each bank has an enable mask, a status word, an address word and a miscellaneous word. A global capability value, a global enable mask and a global status word sit beside the banks. An error source presents an event on the inject port in a single cycle. The event carries a target bank, a status word, a global status word, an address, a miscellaneous word and a flag that forces acceptance. The block then works out what the event means.

The possible outcomes, from highest priority down, are:

- reject the event as malformed;
- ignore it because an earlier machine check is still being handled;
- drop it because reporting is masked off;
- request a system reset;
- record an uncorrected error and raise the machine-check interrupt;
- record a corrected error.

The rules that decide whether an old entry is overwritten or only flagged with overflow follow fixed bit positions in the status word.

The outcome is reported as a registered result code in the cycle after the strobe. The interrupt and reset requests are one-cycle pulses aligned with that code. A simple write port updates the bank masks and the global mask. A combinational read view shows any bank and the global registers.

Top module: `mc_bank_recorder`

## Requirements
- R1: An event is rejected (code 1) when the capability is 0, when the bank number is not below capability bits [7:0] or not below the number of banks, or when status bit 63 (valid) is clear. A rejected event changes no register.
- R2: An event with status bit 55 (action required) clear is ignored (code 2) when global status bit 2 (in progress) is set, unless the force flag is set. An ignored event changes no register.
- R3: An uncorrected event (status bit 61 set) is dropped (code 3) without any change when capability bit 8 is set and the global mask is not all ones. It is also dropped when the target bank's mask is not all ones.
- R4: An uncorrected event that is not dropped requests a reset (code 4, one-cycle reset pulse, no register change) when the machine-check enable input is 0 or the in-progress bit is set.
- R5: Any other uncorrected event is injected (code 5). It writes the bank's address, misc and status words and the global status, and pulses the interrupt. The stored status gets bit 62 (overflow) set if the bank already held a valid entry.
- R6: A corrected event whose bank entry is not valid, or is valid but not uncorrected, overwrites status, address and misc (code 6). Overflow is set if the old entry was valid, and the global status is untouched.
- R7: A corrected event aimed at a bank holding a valid uncorrected entry only sets overflow in the existing status (code 6). Address and misc are kept.
- R8: The result valid flag is high for exactly the one cycle after a strobe cycle, with a non-zero code. Otherwise it is low with code 0.
- R9: After reset all status, address, misc and global status words are 0, and every bank mask and the global mask are all ones.
- R10: The mask write port writes the global mask when its global select is high, and otherwise the mask of the selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_i | input | 9 | Capability: [7:0] bank count, [8] global mask present |
| mce_en_i | input | 1 | Machine-check enable from the control state |
| ctl_we_i | input | 1 | Mask write strobe |
| ctl_global_i | input | 1 | Mask write targets the global mask |
| ctl_bank_i | input | IDX_W | Bank index for a mask write |
| ctl_wdata_i | input | 64 | Mask write data |
| inj_valid_i | input | 1 | Inject strobe |
| inj_bank_i | input | 8 | Target bank number |
| inj_status_i | input | 64 | Event status word |
| inj_gstatus_i | input | 64 | Event global status word |
| inj_addr_i | input | 64 | Event address word |
| inj_misc_i | input | 64 | Event misc word |
| inj_uncond_i | input | 1 | Force acceptance past the in-progress check |
| rd_bank_i | input | IDX_W | Bank shown on the read view |
| rd_ctl_o | output | 64 | Mask of the viewed bank |
| rd_status_o | output | 64 | Status of the viewed bank |
| rd_addr_o | output | 64 | Address of the viewed bank |
| rd_misc_o | output | 64 | Misc of the viewed bank |
| gctl_o | output | 64 | Global mask |
| gstatus_o | output | 64 | Global status |
| res_valid_o | output | 1 | Result valid |
| res_code_o | output | 3 | Result code |
| mce_irq_o | output | 1 | Machine-check interrupt pulse |
| reset_req_o | output | 1 | Reset request pulse |

## Verification
The hardest state to reach is a bank holding a valid uncorrected entry while the in-progress bit is clear. The first injected uncorrected error must carry a global status without the in-progress bit, so that a second uncorrected error can reach the same bank and show the overflow marking. After that the in-progress bit is set and cannot be cleared from the ports. The ignore, force and reset-priority cases therefore follow in that order. A mid-run reset then restores a clean state for the disabled-enable reset case.

// File: rtl/mcbr_pkg.sv
// Shared constants and result encoding for the machine-check bank recorder.
// Assumes 64-bit architectural registers with fixed flag positions.
package mcbr_pkg;
    localparam int REG_W        = 64;
    localparam int VAL_BIT      = 63;
    localparam int OVER_BIT     = 62;
    localparam int UC_BIT       = 61;
    localparam int AR_BIT       = 55;
    localparam int MCIP_BIT     = 2;
    localparam int CAP_W        = 9;
    localparam int CAP_CTLP_BIT = 8;

    typedef enum logic [2:0] {
        RES_NONE   = 3'd0,
        RES_REJECT = 3'd1,
        RES_IGNORE = 3'd2,
        RES_DROP   = 3'd3,
        RES_RESET  = 3'd4,
        RES_INJECT = 3'd5,
        RES_RECORD = 3'd6
    } mcbr_res_e;
endpackage

// File: rtl/mcbr_decide.sv
// Classifies one injected event against the current bank and global state.
// Purely combinational; assumes the caller presents the target bank's old
// mask and status (any value when the bank number is out of range).
module mcbr_decide
    import mcbr_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [7:0]       inj_bank_i,
    input  logic [REG_W-1:0] inj_status_i,
    input  logic             inj_uncond_i,
    input  logic [CAP_W-1:0] cap_i,
    input  logic [REG_W-1:0] gctl_i,
    input  logic [REG_W-1:0] gstatus_i,
    input  logic             mce_en_i,
    input  logic [REG_W-1:0] bank_ctl_i,
    input  logic [REG_W-1:0] bank_status_i,
    output mcbr_res_e        res_o,
    output logic             full_wr_o,
    output logic             over_only_o,
    output logic             gst_wr_o,
    output logic [REG_W-1:0] new_status_o,
    output logic             irq_o,
    output logic             rst_o
);
    localparam logic [8:0] NB9 = 9'(NUM_BANKS);

    logic bank_ok, reject, ignore, drop, need_rst;
    logic is_uc, is_ar, mcip, old_val, old_uc;

    // Derive the individual decision terms from the event and state.
    always_comb begin
        is_uc    = inj_status_i[UC_BIT];
        is_ar    = inj_status_i[AR_BIT];
        mcip     = gstatus_i[MCIP_BIT];
        old_val  = bank_status_i[VAL_BIT];
        old_uc   = bank_status_i[UC_BIT];
        bank_ok  = (inj_bank_i < cap_i[7:0]) && ({1'b0, inj_bank_i} < NB9);
        reject   = (cap_i == '0) || !bank_ok || !inj_status_i[VAL_BIT];
        ignore   = !inj_uncond_i && !is_ar && mcip;
        drop     = (cap_i[CAP_CTLP_BIT] && (gctl_i != '1)) || (bank_ctl_i != '1);
        need_rst = !mce_en_i || mcip;
    end

    // Apply the outcome priority and produce the write controls.
    always_comb begin
        res_o        = RES_NONE;
        full_wr_o    = 1'b0;
        over_only_o  = 1'b0;
        gst_wr_o     = 1'b0;
        irq_o        = 1'b0;
        rst_o        = 1'b0;
        new_status_o = inj_status_i;
        if (old_val) new_status_o[OVER_BIT] = 1'b1;
        if (reject) begin
            res_o = RES_REJECT;
        end else if (ignore) begin
            res_o = RES_IGNORE;
        end else if (is_uc) begin
            if (drop) begin
                res_o = RES_DROP;
            end else if (need_rst) begin
                res_o = RES_RESET;
                rst_o = 1'b1;
            end else begin
                res_o     = RES_INJECT;
                full_wr_o = 1'b1;
                gst_wr_o  = 1'b1;
                irq_o     = 1'b1;
            end
        end else if (!old_val || !old_uc) begin
            res_o     = RES_RECORD;
            full_wr_o = 1'b1;
        end else begin
            res_o       = RES_RECORD;
            over_only_o = 1'b1;
        end
    end
endmodule

// File: rtl/mcbr_bank.sv
// One machine-check bank: mask, status, address and misc registers.
// Assumes at most one record command per cycle; a mask write and a record
// in the same cycle update independent registers.
module mcbr_bank
    import mcbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we_i,
    input  logic [REG_W-1:0] ctl_wdata_i,
    input  logic             full_we_i,
    input  logic             over_we_i,
    input  logic [REG_W-1:0] status_i,
    input  logic [REG_W-1:0] addr_i,
    input  logic [REG_W-1:0] misc_i,
    output logic [REG_W-1:0] ctl_o,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] addr_o,
    output logic [REG_W-1:0] misc_o
);
    // Mask register, resets to all ones (reporting enabled).
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_o <= '1;
        else if (ctl_we_i) ctl_o <= ctl_wdata_i;
    end

    // Error record registers: full overwrite or overflow-only marking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            addr_o   <= '0;
            misc_o   <= '0;
        end else if (full_we_i) begin
            status_o <= status_i;
            addr_o   <= addr_i;
            misc_o   <= misc_i;
        end else if (over_we_i) begin
            status_o[OVER_BIT] <= 1'b1;
        end
    end
endmodule

// File: rtl/mc_bank_recorder.sv
// Machine-check bank recorder top: holds NUM_BANKS banks plus global mask
// and status, classifies each injected event and reports a registered
// result one cycle after the strobe. Assumes a synchronous active-low reset.
module mc_bank_recorder
    import mcbr_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] cap_i,
    input  logic             mce_en_i,
    input  logic             ctl_we_i,
    input  logic             ctl_global_i,
    input  logic [IDX_W-1:0] ctl_bank_i,
    input  logic [REG_W-1:0] ctl_wdata_i,
    input  logic             inj_valid_i,
    input  logic [7:0]       inj_bank_i,
    input  logic [REG_W-1:0] inj_status_i,
    input  logic [REG_W-1:0] inj_gstatus_i,
    input  logic [REG_W-1:0] inj_addr_i,
    input  logic [REG_W-1:0] inj_misc_i,
    input  logic             inj_uncond_i,
    input  logic [IDX_W-1:0] rd_bank_i,
    output logic [REG_W-1:0] rd_ctl_o,
    output logic [REG_W-1:0] rd_status_o,
    output logic [REG_W-1:0] rd_addr_o,
    output logic [REG_W-1:0] rd_misc_o,
    output logic [REG_W-1:0] gctl_o,
    output logic [REG_W-1:0] gstatus_o,
    output logic             res_valid_o,
    output logic [2:0]       res_code_o,
    output logic             mce_irq_o,
    output logic             reset_req_o
);
    logic [REG_W-1:0] bank_ctl    [NUM_BANKS];
    logic [REG_W-1:0] bank_status [NUM_BANKS];
    logic [REG_W-1:0] bank_addr   [NUM_BANKS];
    logic [REG_W-1:0] bank_misc   [NUM_BANKS];
    logic [REG_W-1:0] sel_ctl, sel_status, new_status;
    logic             full_wr, over_only, gst_wr, irq_d, rst_d;
    mcbr_res_e        res_d;

    // Select the target bank's current mask and status for the decision.
    always_comb begin
        sel_ctl    = '1;
        sel_status = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (inj_bank_i == 8'(b)) begin
                sel_ctl    = bank_ctl[b];
                sel_status = bank_status[b];
            end
        end
    end

    mcbr_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
        .inj_bank_i    (inj_bank_i),
        .inj_status_i  (inj_status_i),
        .inj_uncond_i  (inj_uncond_i),
        .cap_i         (cap_i),
        .gctl_i        (gctl_o),
        .gstatus_i     (gstatus_o),
        .mce_en_i      (mce_en_i),
        .bank_ctl_i    (sel_ctl),
        .bank_status_i (sel_status),
        .res_o         (res_d),
        .full_wr_o     (full_wr),
        .over_only_o   (over_only),
        .gst_wr_o      (gst_wr),
        .new_status_o  (new_status),
        .irq_o         (irq_d),
        .rst_o         (rst_d)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = inj_valid_i && (inj_bank_i == 8'(g));
        mcbr_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctl_we_i    (ctl_we_i && !ctl_global_i && (ctl_bank_i == IDX_W'(g))),
            .ctl_wdata_i (ctl_wdata_i),
            .full_we_i   (hit && full_wr),
            .over_we_i   (hit && over_only),
            .status_i    (new_status),
            .addr_i      (inj_addr_i),
            .misc_i      (inj_misc_i),
            .ctl_o       (bank_ctl[g]),
            .status_o    (bank_status[g]),
            .addr_o      (bank_addr[g]),
            .misc_o      (bank_misc[g])
        );
    end

    // Global mask register, resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                         gctl_o <= '1;
        else if (ctl_we_i && ctl_global_i)  gctl_o <= ctl_wdata_i;
    end

    // Global status register, written only by an injected uncorrected event.
    always_ff @(posedge clk) begin
        if (!rst_n)                       gstatus_o <= '0;
        else if (inj_valid_i && gst_wr)   gstatus_o <= inj_gstatus_i;
    end

    // Registered result code and one-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_code_o  <= RES_NONE;
            mce_irq_o   <= 1'b0;
            reset_req_o <= 1'b0;
        end else begin
            res_valid_o <= inj_valid_i;
            res_code_o  <= inj_valid_i ? res_d : RES_NONE;
            mce_irq_o   <= inj_valid_i && irq_d;
            reset_req_o <= inj_valid_i && rst_d;
        end
    end

    // Read view of one bank.
    always_comb begin
        rd_ctl_o    = '0;
        rd_status_o = '0;
        rd_addr_o   = '0;
        rd_misc_o   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank_i == IDX_W'(b)) begin
                rd_ctl_o    = bank_ctl[b];
                rd_status_o = bank_status[b];
                rd_addr_o   = bank_addr[b];
                rd_misc_o   = bank_misc[b];
            end
        end
    end
endmodule

// File: rtl/mcbr_checker.sv
// Temporal checks on the recorder's ports; attached by bind below.
module mcbr_checker
    import mcbr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             inj_valid_i,
    input logic [REG_W-1:0] inj_status_i,
    input logic             res_valid_o,
    input logic [2:0]       res_code_o,
    input logic             mce_irq_o,
    input logic             reset_req_o,
    input logic [REG_W-1:0] gstatus_o
);
    AST_NO_VAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid_i && !inj_status_i[VAL_BIT] |=> res_valid_o && res_code_o == RES_REJECT); // R1
    AST_RESET_PULSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> res_valid_o && res_code_o == RES_RESET && !mce_irq_o); // R4
    AST_IRQ_PULSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mce_irq_o |-> res_valid_o && res_code_o == RES_INJECT); // R5
    AST_GSTATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && res_code_o != RES_INJECT |-> $stable(gstatus_o)); // R6
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_valid_i |=> !res_valid_o && res_code_o == RES_NONE); // R8
    AST_RESULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid_i |=> res_valid_o && res_code_o != RES_NONE); // R8
endmodule

bind mc_bank_recorder mcbr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inj_valid_i  (inj_valid_i),
    .inj_status_i (inj_status_i),
    .res_valid_o  (res_valid_o),
    .res_code_o   (res_code_o),
    .mce_irq_o    (mce_irq_o),
    .reset_req_o  (reset_req_o),
    .gstatus_o    (gstatus_o)
);

// File: tb/mc_bank_recorder_tb.sv
`timescale 1ns/1ps
module mc_bank_recorder_tb;
    localparam logic [63:0] V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] O = 64'h4000_0000_0000_0000;
    localparam logic [63:0] U = 64'h2000_0000_0000_0000;
    localparam logic [63:0] A = 64'h0080_0000_0000_0000;

    typedef struct packed {
        logic [7:0]  bank;
        logic [63:0] st;
        logic [63:0] gst;
        logic        unc;
        logic [63:0] addr;
        logic [2:0]  code;
        logic [63:0] exp_st;
        logic [63:0] exp_addr;
        logic [63:0] exp_gst;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd0, V|64'h11,     64'h0, 1'b0, 64'h1000, 3'd6, V|64'h11,       64'h1000, 64'h0}, // R6 empty bank
        '{8'd0, V|64'h22,     64'h0, 1'b0, 64'h1100, 3'd6, V|O|64'h22,     64'h1100, 64'h0}, // R6 overflow
        '{8'd1, V|U|A|64'h30, 64'h1, 1'b0, 64'h2A00, 3'd5, V|U|A|64'h30,   64'h2A00, 64'h1}, // R5
        '{8'd1, V|U|A|64'h33, 64'h5, 1'b0, 64'h2B00, 3'd5, V|O|U|A|64'h33, 64'h2B00, 64'h5}, // R5 overflow
        '{8'd1, V|64'h44,     64'h0, 1'b0, 64'h3300, 3'd2, V|O|U|A|64'h33, 64'h2B00, 64'h5}, // R2
        '{8'd1, V|64'h44,     64'h0, 1'b1, 64'h4400, 3'd6, V|O|U|A|64'h33, 64'h2B00, 64'h5}, // R7 keep UC entry
        '{8'd2, V|U|A|64'h55, 64'h0, 1'b0, 64'h5500, 3'd4, 64'h0,          64'h0,    64'h5}, // R4 in progress
        '{8'd4, V|64'h1,      64'h0, 1'b0, 64'h6600, 3'd1, V|O|64'h22,     64'h1100, 64'h5}, // R1 bank range
        '{8'd0, 64'h77,       64'h0, 1'b0, 64'h7700, 3'd1, V|O|64'h22,     64'h1100, 64'h5}, // R1 no valid
        '{8'd2, V|U|64'h88,   64'h0, 1'b1, 64'h8800, 3'd4, 64'h0,          64'h0,    64'h5}, // R4 forced
        '{8'd3, V|64'h99,     64'h0, 1'b1, 64'h9900, 3'd6, V|64'h99,       64'h9900, 64'h5}, // R6
        '{8'd3, V|A|64'hAA,   64'h0, 1'b0, 64'hAA00, 3'd6, V|O|A|64'hAA,   64'hAA00, 64'h5}  // R6 corrected over corrected
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cap = 9'h104;
    logic        mce_en = 1'b1;
    logic        ctl_we = 1'b0, ctl_global = 1'b0;
    logic [1:0]  ctl_bank = '0;
    logic [63:0] ctl_wdata = '0;
    logic        inj_valid = 1'b0, inj_uncond = 1'b0;
    logic [7:0]  inj_bank = '0;
    logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
    logic [1:0]  rd_bank = '0;
    logic [63:0] rd_ctl, rd_status, rd_addr, rd_misc, gctl, gstatus;
    logic        res_valid, mce_irq, reset_req;
    logic [2:0]  res_code;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    mc_bank_recorder #(.NUM_BANKS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .mce_en_i(mce_en),
        .ctl_we_i(ctl_we), .ctl_global_i(ctl_global), .ctl_bank_i(ctl_bank),
        .ctl_wdata_i(ctl_wdata), .inj_valid_i(inj_valid), .inj_bank_i(inj_bank),
        .inj_status_i(inj_status), .inj_gstatus_i(inj_gstatus), .inj_addr_i(inj_addr),
        .inj_misc_i(inj_misc), .inj_uncond_i(inj_uncond), .rd_bank_i(rd_bank),
        .rd_ctl_o(rd_ctl), .rd_status_o(rd_status), .rd_addr_o(rd_addr),
        .rd_misc_o(rd_misc), .gctl_o(gctl), .gstatus_o(gstatus),
        .res_valid_o(res_valid), .res_code_o(res_code), .mce_irq_o(mce_irq),
        .reset_req_o(reset_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string code_req(input logic [2:0] c);
        case (c)
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Drive one event, sample the registered result, then check R8 idle.
    task automatic inject(input logic [7:0] b, input logic [63:0] st, input logic [63:0] gst,
                          input logic unc, input logic [63:0] ad);
        @(negedge clk);
        inj_valid = 1'b1; inj_bank = b; inj_status = st; inj_gstatus = gst;
        inj_uncond = unc; inj_addr = ad; inj_misc = ~ad;
        @(negedge clk);
        inj_valid = 1'b0;
        chk("R8 valid after strobe", {63'b0, res_valid}, 64'd1);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R8 valid drops", {63'b0, res_valid}, 64'd0);
        chk("R8 code idle", {61'b0, res_code}, 64'd0);
    endtask

    task automatic write_ctl(input logic glob, input logic [1:0] b, input logic [63:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_global = glob; ctl_bank = b; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 4; b++) begin
            rd_bank = 2'(b);
            #1;
            chk("R9 bank status", rd_status, 64'h0);
            chk("R9 bank addr", rd_addr, 64'h0);
            chk("R9 bank misc", rd_misc, 64'h0);
            chk("R9 bank mask", rd_ctl, '1);
        end
        chk("R9 global mask", gctl, '1);
        chk("R9 global status", gstatus, 64'h0);
        chk("R9 result idle", {60'b0, res_valid, res_code}, 64'h0);
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: state builds up from vector to vector.
        for (int i = 0; i < NV; i++) begin
            rd_bank = VECS[i].bank[1:0];
            inject(VECS[i].bank, VECS[i].st, VECS[i].gst, VECS[i].unc, VECS[i].addr);
            chk({code_req(VECS[i].code), " code"}, {61'b0, res_code}, {61'b0, VECS[i].code});
            chk({code_req(VECS[i].code), " status"}, rd_status, VECS[i].exp_st);
            chk({code_req(VECS[i].code), " addr"}, rd_addr, VECS[i].exp_addr);
            chk({code_req(VECS[i].code), " misc"}, rd_misc,
                (VECS[i].exp_addr == 64'h0) ? 64'h0 : ~VECS[i].exp_addr);
            chk({code_req(VECS[i].code), " gstatus"}, gstatus, VECS[i].exp_gst);
            chk("R5 irq pulse", {63'b0, mce_irq}, {63'b0, VECS[i].code == 3'd5});
            chk("R4 reset pulse", {63'b0, reset_req}, {63'b0, VECS[i].code == 3'd4});
            idle_check();
        end

        // R10 bank mask write, then R3 bank-mask drop outranks reset.
        write_ctl(1'b0, 2'd3, 64'h0);
        rd_bank = 2'd3;
        #1;
        chk("R10 bank mask write", rd_ctl, 64'h0);
        inject(8'd3, V|U|A|64'hBB, 64'h0, 1'b0, 64'hBB00);
        chk("R3 bank mask drop code", {61'b0, res_code}, 64'd3);
        chk("R3 no reset on drop", {63'b0, reset_req}, 64'd0);
        chk("R3 bank untouched", rd_status, V|O|A|64'hAA);

        // R10 global mask write, R3 global drop, then R4 once mask not present.
        write_ctl(1'b1, 2'd0, 64'h0);
        chk("R10 global mask write", gctl, 64'h0);
        rd_bank = 2'd0;
        inject(8'd0, V|U|A|64'hCC, 64'h0, 1'b0, 64'hCC00);
        chk("R3 global mask drop code", {61'b0, res_code}, 64'd3);
        chk("R3 status kept", rd_status, V|O|64'h22);
        cap = 9'h004;
        inject(8'd0, V|U|A|64'hCC, 64'h0, 1'b0, 64'hCC00);
        chk("R4 mask ignored without present bit", {61'b0, res_code}, 64'd4);

        // R1 zero capability rejects a valid event.
        cap = 9'h000;
        inject(8'd0, V|64'h1, 64'h0, 1'b0, 64'h0);
        chk("R1 zero capability", {61'b0, res_code}, 64'd1);
        idle_check();

        // R4 machine checks disabled after a fresh reset.
        cap = 9'h104;
        do_reset();
        mce_en = 1'b0;
        rd_bank = 2'd0;
        inject(8'd0, V|U|A|64'hDD, 64'h9, 1'b0, 64'hDD00);
        chk("R4 disabled reset code", {61'b0, res_code}, 64'd4);
        chk("R4 disabled reset pulse", {63'b0, reset_req}, 64'd1);
        chk("R4 no record", rd_status, 64'h0);
        chk("R4 gstatus kept", gstatus, 64'h0);
        mce_en = 1'b1;
        inject(8'd0, V|U|A|64'hDD, 64'h9, 1'b0, 64'hDD00);
        chk("R5 inject code", {61'b0, res_code}, 64'd5);
        chk("R5 irq", {63'b0, mce_irq}, 64'd1);
        chk("R5 status no overflow", rd_status, V|U|A|64'hDD);
        chk("R5 gstatus written", gstatus, 64'h9);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule